// File: doc/BRIEF.md
# Bus-Sizing Byte-Enable Splitter

This block sits beside a 32-bit bus master that drives a local bus where the addressed target may be only 16 bits wide. When a transfer starts, it captures the active-low byte enables of the access and presents them as the enables of the cycle now on the bus. From a fixed lookup it also offers the enables that a follow-up cycle would carry. A follow-up is needed when active lanes lie in both half-words.

In the clock where the first cycle's ready arrives, the block samples a narrow-target indication. Suppose that indication is active, the block is not itself the target, and the pattern spans both halves. The block then opens a second cycle that carries only the upper half-word lanes and raises a flag for that cycle. Otherwise the transfer ends after one cycle. A one-clock done strobe follows the final ready. When the device itself is the addressed target, it always behaves as a 32-bit peripheral, so the narrow indication is ignored. All state changes occur on the rising clock edge.

Top module: `be_width_splitter`

## Requirements
- R1: In the cycle after a synchronous active-high reset, `need_second` and `done` are 0, and `be_cur_n` and `be_next_n` are all ones (no lane enabled).
- R2: A `start` pulse while idle places `be_req_n` on `be_cur_n` from the next cycle. A `start` seen while a transfer is in progress has no effect on `be_cur_n`.
- R3: While a first cycle is on the bus, `be_next_n` = {be_cur_n[3:2], 2'b11} if at least one of lanes 0–1 and at least one of lanes 2–3 are enabled (a bit is 0). Otherwise `be_next_n` is 4'b1111. In the second cycle, and while idle, it is 4'b1111.
- R4: If `rdy` and `narrow` are 1, `self_tgt` is 0, and the first-cycle pattern spans both halves, then in the next cycle `need_second` is 1 and `be_cur_n` equals the lookup value of R3. For example, 0000 leads to 0011, 1000 to 1011, 1001 to 1011, and 0001 to 0011.
- R5: A pattern whose enabled lanes lie in one half-word only completes in one cycle, even when `narrow` is 1. Examples are 1110, 1100, 0011 and 0111.
- R6: If `narrow` is 0 at the first cycle's `rdy`, the transfer completes in one cycle.
- R7: If `self_tgt` is 1 at the first cycle's `rdy`, `narrow` is ignored and the transfer completes in one cycle.
- R8: `done` is 1 for exactly the one cycle after the final `rdy`. In that cycle `need_second` is 0 and `be_cur_n` is 4'b1111.
- R9: While a cycle is pending and `rdy` is 0, `be_cur_n` and `need_second` hold their values, and `narrow` has no effect.
- R10: A reset during a pending second cycle returns the block to idle, with no second cycle pending and no `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local 1x clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a transfer with `be_req_n` (honoured only when idle) |
| be_req_n | input | 4 | Active-low byte enables of the new 32-bit access |
| rdy | input | 1 | Ready: the current bus cycle completes this clock |
| narrow | input | 1 | Target is 16 bits wide, sampled with the first `rdy` |
| self_tgt | input | 1 | The device itself is the target; `narrow` is ignored |
| be_cur_n | output | 4 | Active-low enables of the cycle on the bus |
| be_next_n | output | 4 | Active-low enables for a follow-up cycle |
| need_second | output | 1 | A second cycle is in progress |
| done | output | 1 | One-clock pulse after the transfer's final cycle |

## Verification
The hardest state to reach from the ports is a pending second cycle that is hit by other events. These events are a reset, a stray `start`, or toggling of `narrow` while `rdy` is held low. Reaching that state needs a spanning pattern, `narrow` high, `self_tgt` low and `rdy` all in one specific clock. The random stimulus therefore draws enable patterns from all sixteen values and holds off `rdy` for random wait counts. During those waits it keeps firing `start` with unrelated enables and flipping `narrow`. A directed step resets the block while a second cycle is pending.

// File: rtl/be_split_pkg.sv
package be_split_pkg;
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_FIRST  = 2'd1,
        PH_SECOND = 2'd2
    } phase_e;
endpackage

// File: rtl/be_split_map.sv
module be_split_map #(
    parameter int LANES = 4
) (
    input  logic [LANES-1:0] be_n,
    output logic             spans,
    output logic [LANES-1:0] follow_n
);
    localparam int HALF = LANES / 2;
    localparam int NHALVES = 2;

    logic [NHALVES-1:0] half_used;

    // A half-word is in use when any of its lanes is enabled (low)
    for (genvar h = 0; h < NHALVES; h++) begin : g_half
        assign half_used[h] = ~&be_n[h*HALF +: HALF];
    end

    always_comb begin
        spans = &half_used;
        if (spans) begin
            follow_n = {be_n[LANES-1:HALF], {HALF{1'b1}}};
        end else begin
            follow_n = '1;
        end
    end
endmodule

// File: rtl/be_split_ctl.sv
module be_split_ctl
    import be_split_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [LANES-1:0] be_req_n,
    input  logic             rdy,
    input  logic             narrow,
    input  logic             self_tgt,
    input  logic             spans,
    input  logic [LANES-1:0] follow_n,
    output logic [LANES-1:0] be_cur_n,
    output logic             need_second,
    output logic             done
);
    localparam int HALF = LANES / 2;

    typedef struct packed {
        phase_e           phase;
        logic [LANES-1:0] be;
        logic             done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        unique case (ctl_q.phase)
            PH_IDLE: begin
                if (start) begin
                    ctl_d.phase = PH_FIRST;
                    ctl_d.be    = be_req_n;
                end
            end
            PH_FIRST: begin
                if (rdy) begin
                    if (narrow && !self_tgt && spans) begin
                        ctl_d.phase = PH_SECOND;
                        ctl_d.be    = follow_n;
                    end else begin
                        ctl_d.phase = PH_IDLE;
                        ctl_d.be    = '1;
                        ctl_d.done  = 1'b1;
                    end
                end
            end
            PH_SECOND: begin
                if (rdy) begin
                    ctl_d.phase = PH_IDLE;
                    ctl_d.be    = '1;
                    ctl_d.done  = 1'b1;
                end
            end
            default: begin
                ctl_d.phase = PH_IDLE;
                ctl_d.be    = '1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q.phase <= PH_IDLE;
            ctl_q.be    <= '1;
            ctl_q.done  <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign be_cur_n    = ctl_q.be;
    assign need_second = (ctl_q.phase == PH_SECOND);
    assign done        = ctl_q.done;

    // R4: a second cycle never carries lower half-word lanes
    a_r4_upper_only: assert property (@(posedge clk) disable iff (rst)
        need_second |-> (&be_cur_n[HALF-1:0]));

    // R6: a wide target finishes after the first ready
    a_r6_wide_one_cycle: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.phase == PH_FIRST && rdy && !narrow) |=> (!need_second && done));

    // R7: self-targeted accesses never split
    a_r7_self_no_split: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.phase == PH_FIRST && rdy && self_tgt) |=> (ctl_q.phase == PH_IDLE && done));

    // R8: done is a single-cycle pulse
    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: enables hold while waiting for ready
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.phase != PH_IDLE && !rdy) |=> $stable(be_cur_n));

    // R10: reset always lands in idle
    a_r10_reset_idle: assert property (@(posedge clk)
        rst |=> (ctl_q.phase == PH_IDLE && !done));
endmodule

// File: rtl/be_width_splitter.sv
module be_width_splitter #(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [LANES-1:0] be_req_n,
    input  logic             rdy,
    input  logic             narrow,
    input  logic             self_tgt,
    output logic [LANES-1:0] be_cur_n,
    output logic [LANES-1:0] be_next_n,
    output logic             need_second,
    output logic             done
);
    logic             spans;
    logic [LANES-1:0] follow_n;

    be_split_map #(.LANES(LANES)) u_map (
        .be_n     (be_cur_n),
        .spans    (spans),
        .follow_n (follow_n)
    );

    be_split_ctl #(.LANES(LANES)) u_ctl (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .be_req_n    (be_req_n),
        .rdy         (rdy),
        .narrow      (narrow),
        .self_tgt    (self_tgt),
        .spans       (spans),
        .follow_n    (follow_n),
        .be_cur_n    (be_cur_n),
        .need_second (need_second),
        .done        (done)
    );

    assign be_next_n = follow_n;

    // R3: the follow-up lookup is always all-idle while a second cycle runs
    a_r3_second_no_follow: assert property (@(posedge clk) disable iff (rst)
        need_second |-> (be_next_n == '1));
endmodule

// File: tb/be_width_splitter_test.sv
`timescale 1ns/1ps
module be_width_splitter_test;
    logic       clk = 1'b0;
    logic       rst;
    logic       start;
    logic [3:0] be_req_n;
    logic       rdy;
    logic       narrow;
    logic       self_tgt;
    logic [3:0] be_cur_n;
    logic [3:0] be_next_n;
    logic       need_second;
    logic       done;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    be_width_splitter uut (
        .clk(clk), .rst(rst), .start(start), .be_req_n(be_req_n),
        .rdy(rdy), .narrow(narrow), .self_tgt(self_tgt),
        .be_cur_n(be_cur_n), .be_next_n(be_next_n),
        .need_second(need_second), .done(done)
    );

    function automatic logic [3:0] ref_follow(input logic [3:0] be);
        int lo = 0;
        int hi = 0;
        for (int i = 0; i < 4; i++) begin
            if (!be[i]) begin
                if (i < 2) lo++;
                else hi++;
            end
        end
        return (lo > 0 && hi > 0) ? {be[3], be[2], 2'b11} : 4'b1111;
    endfunction

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            summary();
        end
    end

    // One full transfer; all driving and sampling at negedge
    task automatic xfer(input logic [3:0] be, input logic nar, input logic slf,
                        input int w1, input int w2, input bit noise);
        logic [3:0] fol;
        bit split;
        fol = ref_follow(be);
        split = nar && !slf && (fol != 4'b1111);
        start = 1'b1; be_req_n = be; rdy = 1'b0;
        @(negedge clk);
        start = 1'b0;
        check("R2 capture", be_cur_n, be);
        check("R3 lookup", be_next_n, fol);
        check("R2 no flags", {2'b00, need_second, done}, 4'b0000);
        for (int i = 0; i < w1; i++) begin
            if (noise) begin
                start = 1'b1; be_req_n = ~be; narrow = $urandom_range(0, 1);
            end
            @(negedge clk);
            start = 1'b0;
            check("R9 hold first", be_cur_n, be);
            check("R2 busy start ignored", {3'b000, need_second}, 4'b0000);
        end
        rdy = 1'b1; narrow = nar; self_tgt = slf;
        @(negedge clk);
        rdy = 1'b0; self_tgt = 1'b0;
        if (split) begin
            check("R4 second flag", {3'b000, need_second}, 4'b0001);
            check("R4 second enables", be_cur_n, fol);
            check("R3 second lookup", be_next_n, 4'b1111);
            check("R8 no early done", {3'b000, done}, 4'b0000);
            for (int i = 0; i < w2; i++) begin
                if (noise) begin
                    start = 1'b1; be_req_n = ~be; narrow = $urandom_range(0, 1);
                end
                @(negedge clk);
                start = 1'b0;
                check("R9 hold second", {be_cur_n[3:0]}, fol);
                check("R9 flag held", {3'b000, need_second}, 4'b0001);
            end
            rdy = 1'b1;
            @(negedge clk);
            rdy = 1'b0;
        end else begin
            if (slf) check("R7 self one cycle", {3'b000, need_second}, 4'b0000);
            else if (!nar) check("R6 wide one cycle", {3'b000, need_second}, 4'b0000);
            else check("R5 single half one cycle", {3'b000, need_second}, 4'b0000);
        end
        check("R8 done pulse", {2'b00, need_second, done}, 4'b0001);
        check("R8 idle enables", be_cur_n, 4'b1111);
        @(negedge clk);
        check("R8 done single", {3'b000, done}, 4'b0000);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'h5eed);
        rst = 1'b1; start = 1'b0; be_req_n = 4'hF; rdy = 1'b0; narrow = 1'b0; self_tgt = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R1 reset flags", {2'b00, need_second, done}, 4'b0000);
        check("R1 reset enables", be_cur_n, 4'b1111);
        check("R1 reset follow", be_next_n, 4'b1111);
        rst = 1'b0;
        @(negedge clk);

        // directed spanning patterns (R4)
        xfer(4'b0000, 1, 0, 0, 0, 0);
        xfer(4'b1000, 1, 0, 1, 2, 0);
        xfer(4'b1001, 1, 0, 0, 1, 1);
        xfer(4'b0001, 1, 0, 2, 0, 0);
        // single half-word patterns (R5)
        xfer(4'b1110, 1, 0, 0, 0, 0);
        xfer(4'b1100, 1, 0, 1, 0, 0);
        xfer(4'b0011, 1, 0, 0, 0, 0);
        xfer(4'b0111, 1, 0, 0, 0, 0);
        // wide target (R6) and self target (R7)
        xfer(4'b0000, 0, 0, 0, 0, 0);
        xfer(4'b0000, 1, 1, 1, 0, 1);
        xfer(4'b1001, 1, 1, 0, 0, 0);

        // R10: reset while a second cycle is pending
        start = 1'b1; be_req_n = 4'b0000;
        @(negedge clk);
        start = 1'b0; rdy = 1'b1; narrow = 1'b1;
        @(negedge clk);
        rdy = 1'b0;
        check("R10 precondition", {3'b000, need_second}, 4'b0001);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R10 reset flags", {2'b00, need_second, done}, 4'b0000);
        check("R10 reset enables", be_cur_n, 4'b1111);
        @(negedge clk);
        check("R10 no late done", {3'b000, done}, 4'b0000);

        // constrained random
        for (int n = 0; n < 400; n++) begin
            logic [3:0] be;
            be = 4'($urandom_range(0, 15));
            xfer(be, 1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 4) == 0),
                 $urandom_range(0, 3), $urandom_range(0, 3), 1'($urandom_range(0, 1)));
        end
        summary();
    end
endmodule